// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This block chooses the handler vector for a synchronous exception or a debug event and records the processor state that the handler will need. The pipeline raises a one-cycle request. With it come the PC of the faulting instruction, a cause code and, when one exists, a faulting address. The current status fields also arrive: exception-mode flag, user-mode flag and interrupt level. One clock edge later the unit presents the vector with a one-cycle valid pulse. It also presents the updated save registers and a new set of status fields with a write strobe, which the owner of the status register applies.

Three vectors serve ordinary exceptions. A request in user mode goes to the user vector. A request outside user mode goes to the kernel vector. A request that arrives while exception mode is already set goes to the double-exception vector, which has its own PC save register when the configuration provides one. Debug events have a separate path. A debug event is accepted only below a configured interrupt level. When it is accepted, the unit snapshots the old status and raises the interrupt level to the debug level.

Top module: `exc_dispatch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge.
- R2: An exception request with exception mode clear and user mode clear selects the kernel vector (code 0) and writes the PC into `save_pc_o`.
- R3: An exception request with exception mode clear and user mode set selects the user vector (code 1) and writes the PC into `save_pc_o`.
- R4: An exception request with exception mode set selects the double vector (code 2). With `HAS_DBL_SAVE`=1 the PC goes to `dbl_save_pc_o` and `save_pc_o` is unchanged. With `HAS_DBL_SAVE`=0 the PC goes to `save_pc_o`.
- R5: Every dispatched exception writes the cause into `fault_code_o`. It pulses `st_wr_o` with exception mode set and with user mode and interrupt level passed through unchanged.
- R6: `fault_addr_o` takes the request's address only when `exc_vaddr_vld_i` is high. Otherwise it keeps its previous value.
- R7: A debug request with interrupt level below `DBG_LEVEL` (default 6) selects the debug vector (code 3). It writes `dbg_code_o` and `dbg_save_pc_o`, and it stores the old status in `dbg_save_st_o` as {exception mode [5], user mode [4], interrupt level [3:0]}. The new status has exception mode set, interrupt level `DBG_LEVEL` and user mode unchanged.
- R8: A debug request with interrupt level at or above `DBG_LEVEL` is ignored: no pulse, no register change. An exception request in the same cycle is dispatched normally.
- R9: An accepted debug request wins over a simultaneous exception request, and the exception save registers stay unchanged.
- R10: `vec_vld_o` and all updates appear one cycle after the request edge. The valid pulse lasts one cycle per request, and the status outputs hold their values between dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 1 | Synchronous exception request strobe |
| exc_pc_i | input | XLEN | PC of the faulting instruction |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| exc_vaddr_i | input | XLEN | Faulting virtual address |
| exc_vaddr_vld_i | input | 1 | Faulting address is meaningful |
| dbg_req_i | input | 1 | Debug event request strobe |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| st_excmode_i | input | 1 | Current exception-mode flag |
| st_user_i | input | 1 | Current user-mode flag |
| st_ilvl_i | input | ILVL_W | Current interrupt level |
| vec_vld_o | output | 1 | One-cycle vector valid pulse |
| vec_o | output | 2 | Vector code: 0 kernel, 1 user, 2 double, 3 debug |
| st_wr_o | output | 1 | Status write strobe |
| st_excmode_o | output | 1 | New exception-mode flag |
| st_user_o | output | 1 | New user-mode flag |
| st_ilvl_o | output | ILVL_W | New interrupt level |
| save_pc_o | output | XLEN | First-level exception PC save register |
| dbl_save_pc_o | output | XLEN | Double-exception PC save register |
| fault_code_o | output | CAUSE_W | Last exception cause |
| fault_addr_o | output | XLEN | Last faulting address |
| dbg_code_o | output | DCAUSE_W | Last debug cause |
| dbg_save_pc_o | output | XLEN | PC save register for the debug level |
| dbg_save_st_o | output | ILVL_W+2 | Status snapshot for the debug level |

## Verification
A wrong internal decision is visible at the ports one cycle after the request, because every save register and the vector are exposed directly. A mis-decoded double-exception condition puts the PC in the wrong save register and shows the wrong vector code on that same cycle. A wrong debug-level comparison shows up either as a missing pulse or as an unexpected status snapshot. A stray write enable becomes visible when a register that should have held changes on a cycle where the request did not permit it, as with the faulting address after an update flagged not valid. Every request is therefore followed by a check of all save registers, not just the one that should change.

// File: rtl/exc_disp_pkg.sv
// Shared types for the exception vector dispatch unit.
// Assumes a two-bit vector code agreed with the fetch redirect logic.
package exc_disp_pkg;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;

    // Vector for an ordinary exception from the current mode flags.
    function automatic vec_e pick_exc_vec(input logic excmode, input logic user);
        if (excmode)   return VEC_DOUBLE;
        else if (user) return VEC_USER;
        else           return VEC_KERNEL;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Decides which request is taken this cycle and which vector it selects.
// Assumes requests are single-cycle strobes; purely combinational.
module exc_arbiter
    import exc_disp_pkg::*;
#(
    parameter int ILVL_W    = 4,
    parameter int DBG_LEVEL = 6
) (
    input  logic              exc_req,
    input  logic              dbg_req,
    input  logic              excmode,
    input  logic              user,
    input  logic [ILVL_W-1:0] ilvl,
    output logic              take_exc,
    output logic              take_dbg,
    output logic              is_double,
    output vec_e              vec
);
    localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

    // Debug accepted below its level; it outranks an ordinary exception.
    always_comb begin
        take_dbg  = dbg_req && (ilvl < DBG_LVL_V);
        take_exc  = exc_req && !take_dbg;
        is_double = excmode;
        vec       = take_dbg ? VEC_DEBUG : pick_exc_vec(excmode, user);
    end
endmodule

// File: rtl/exc_save_regs.sv
// Holds the exception save state: first-level PC, double-exception PC,
// cause and faulting address. HAS_DBL_SAVE picks whether a separate
// double-exception PC register exists.
module exc_save_regs #(
    parameter int XLEN         = 32,
    parameter int CAUSE_W      = 6,
    parameter bit HAS_DBL_SAVE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_exc,
    input  logic               is_double,
    input  logic [XLEN-1:0]    pc,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    vaddr,
    input  logic               vaddr_vld,
    output logic [XLEN-1:0]    save_pc,
    output logic [XLEN-1:0]    dbl_save_pc,
    output logic [CAUSE_W-1:0] fault_code,
    output logic [XLEN-1:0]    fault_addr
);
    logic wr_save, wr_dbl;

    generate
        if (HAS_DBL_SAVE) begin : g_dbl
            // Route the PC by exception depth.
            always_comb begin
                wr_save = take_exc && !is_double;
                wr_dbl  = take_exc &&  is_double;
            end
            // Double-exception PC register.
            always_ff @(posedge clk) begin
                if (!rst_n)      dbl_save_pc <= '0;
                else if (wr_dbl) dbl_save_pc <= pc;
            end
        end else begin : g_nodbl
            // Without a double register every PC goes to the first-level one.
            always_comb begin
                wr_save = take_exc || (take_exc && is_double);
                wr_dbl  = 1'b0;
            end
            assign dbl_save_pc = '0;
        end
    endgenerate

    // First-level PC, cause and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pc    <= '0;
            fault_code <= '0;
            fault_addr <= '0;
        end else begin
            if (wr_save)              save_pc    <= pc;
            if (take_exc)             fault_code <= cause;
            if (take_exc && vaddr_vld) fault_addr <= vaddr;
        end
    end

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_exc && vaddr_vld) |=> $stable(fault_addr));

    // R4
    dbl_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DBL_SAVE && take_exc && is_double) |=> $stable(save_pc));
endmodule

// File: rtl/dbg_save_regs.sv
// Holds the debug-entry state: debug cause, PC and status snapshot for
// the configured debug level. Written only when a debug entry is taken.
module dbg_save_regs #(
    parameter int XLEN     = 32,
    parameter int DCAUSE_W = 6,
    parameter int ST_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_dbg,
    input  logic [XLEN-1:0]     pc,
    input  logic [DCAUSE_W-1:0] dcause,
    input  logic [ST_W-1:0]     st_snap,
    output logic [DCAUSE_W-1:0] dbg_code,
    output logic [XLEN-1:0]     dbg_save_pc,
    output logic [ST_W-1:0]     dbg_save_st
);
    // Capture the debug entry state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_code    <= '0;
            dbg_save_pc <= '0;
            dbg_save_st <= '0;
        end else if (take_dbg) begin
            dbg_code    <= dcause;
            dbg_save_pc <= pc;
            dbg_save_st <= st_snap;
        end
    end

    // R8
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_dbg |=> ($stable(dbg_save_pc) && $stable(dbg_save_st)));
endmodule

// File: rtl/exc_dispatch_unit.sv
// Exception vector dispatch unit top. Registers the vector with a
// one-cycle valid and produces the new status fields. Assumes the caller
// applies the status write and redirects fetch from the vector code.
module exc_dispatch_unit
    import exc_disp_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int CAUSE_W      = 6,
    parameter int DCAUSE_W     = 6,
    parameter int ILVL_W       = 4,
    parameter int DBG_LEVEL    = 6,
    parameter bit HAS_DBL_SAVE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_req_i,
    input  logic [XLEN-1:0]     exc_pc_i,
    input  logic [CAUSE_W-1:0]  exc_cause_i,
    input  logic [XLEN-1:0]     exc_vaddr_i,
    input  logic                exc_vaddr_vld_i,
    input  logic                dbg_req_i,
    input  logic [DCAUSE_W-1:0] dbg_cause_i,
    input  logic                st_excmode_i,
    input  logic                st_user_i,
    input  logic [ILVL_W-1:0]   st_ilvl_i,
    output logic                vec_vld_o,
    output logic [1:0]          vec_o,
    output logic                st_wr_o,
    output logic                st_excmode_o,
    output logic                st_user_o,
    output logic [ILVL_W-1:0]   st_ilvl_o,
    output logic [XLEN-1:0]     save_pc_o,
    output logic [XLEN-1:0]     dbl_save_pc_o,
    output logic [CAUSE_W-1:0]  fault_code_o,
    output logic [XLEN-1:0]     fault_addr_o,
    output logic [DCAUSE_W-1:0] dbg_code_o,
    output logic [XLEN-1:0]     dbg_save_pc_o,
    output logic [ILVL_W+1:0]   dbg_save_st_o
);
    localparam int ST_W = ILVL_W + 2;
    localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

    logic take_exc, take_dbg, is_double, any_take;
    vec_e vec_sel;
    logic [ST_W-1:0] st_snap;
    logic [ILVL_W-1:0] ilvl_next;

    exc_arbiter #(.ILVL_W(ILVL_W), .DBG_LEVEL(DBG_LEVEL)) arb_i (
        .exc_req(exc_req_i), .dbg_req(dbg_req_i),
        .excmode(st_excmode_i), .user(st_user_i), .ilvl(st_ilvl_i),
        .take_exc(take_exc), .take_dbg(take_dbg),
        .is_double(is_double), .vec(vec_sel)
    );

    exc_save_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DBL_SAVE(HAS_DBL_SAVE)) exc_regs_i (
        .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .is_double(is_double),
        .pc(exc_pc_i), .cause(exc_cause_i), .vaddr(exc_vaddr_i),
        .vaddr_vld(exc_vaddr_vld_i),
        .save_pc(save_pc_o), .dbl_save_pc(dbl_save_pc_o),
        .fault_code(fault_code_o), .fault_addr(fault_addr_o)
    );

    dbg_save_regs #(.XLEN(XLEN), .DCAUSE_W(DCAUSE_W), .ST_W(ST_W)) dbg_regs_i (
        .clk(clk), .rst_n(rst_n), .take_dbg(take_dbg),
        .pc(exc_pc_i), .dcause(dbg_cause_i), .st_snap(st_snap),
        .dbg_code(dbg_code_o), .dbg_save_pc(dbg_save_pc_o),
        .dbg_save_st(dbg_save_st_o)
    );

    // Status snapshot and next interrupt level.
    always_comb begin
        st_snap   = {st_excmode_i, st_user_i, st_ilvl_i};
        any_take  = take_exc || take_dbg;
        ilvl_next = take_dbg ? DBG_LVL_V : st_ilvl_i;
    end

    // Registered vector, valid pulse and status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_vld_o    <= 1'b0;
            vec_o        <= 2'd0;
            st_wr_o      <= 1'b0;
            st_excmode_o <= 1'b0;
            st_user_o    <= 1'b0;
            st_ilvl_o    <= '0;
        end else begin
            vec_vld_o <= any_take;
            st_wr_o   <= any_take;
            if (any_take) begin
                vec_o        <= vec_sel;
                st_excmode_o <= 1'b1;
                st_user_o    <= st_user_i;
                st_ilvl_o    <= ilvl_next;
            end
        end
    end

    // R5
    excmode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (st_excmode_o && st_wr_o));

    // R4
    double_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req_i && st_excmode_i && !dbg_req_i))
        |-> (vec_vld_o && vec_o == VEC_DOUBLE));

    // R8
    dbg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dbg_req_i && !exc_req_i && st_ilvl_i >= DBG_LVL_V))
        |-> !vec_vld_o);

    // R7
    dbg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld_o && vec_o == VEC_DEBUG) |-> (st_ilvl_o == DBG_LVL_V));

    // R10
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && vec_vld_o) |-> $past(exc_req_i || dbg_req_i));
endmodule

// File: tb/exc_dispatch_unit_tb.sv
// Self-checking bench for the exception vector dispatch unit.
module exc_dispatch_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, vaddr_vld = 1'b0, dbg_req = 1'b0;
    logic [31:0] pc = '0, vaddr = '0;
    logic [5:0]  cause = '0, dcause = '0;
    logic        excm = 1'b0, um = 1'b0;
    logic [3:0]  ilvl = '0;

    logic        vec_vld, st_wr, st_excm_o, st_um_o;
    logic [1:0]  vec;
    logic [3:0]  st_ilvl_o;
    logic [31:0] save_pc, dbl_pc, faddr, dpc;
    logic [5:0]  fcode, dcode, dst;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_dispatch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_pc_i(pc),
        .exc_cause_i(cause), .exc_vaddr_i(vaddr), .exc_vaddr_vld_i(vaddr_vld),
        .dbg_req_i(dbg_req), .dbg_cause_i(dcause), .st_excmode_i(excm),
        .st_user_i(um), .st_ilvl_i(ilvl), .vec_vld_o(vec_vld), .vec_o(vec),
        .st_wr_o(st_wr), .st_excmode_o(st_excm_o), .st_user_o(st_um_o),
        .st_ilvl_o(st_ilvl_o), .save_pc_o(save_pc), .dbl_save_pc_o(dbl_pc),
        .fault_code_o(fcode), .fault_addr_o(faddr), .dbg_code_o(dcode),
        .dbg_save_pc_o(dpc), .dbg_save_st_o(dst)
    );

    // Vector fields: [10] exc, [9] dbg, [8] excmode, [7] user, [6:3] level,
    // [2] expected valid, [1:0] expected vector code.
    localparam logic [10:0] TBL [12] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 2'd0},
        {1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  1'b1, 2'd1},
        {1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  1'b1, 2'd2},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd5,  1'b1, 2'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd2,  1'b1, 2'd3},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd6,  1'b0, 2'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  1'b1, 2'd3},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd7,  1'b1, 2'd2},
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 2'd0},
        {1'b0, 1'b1, 1'b1, 1'b1, 4'd5,  1'b1, 2'd3},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd6,  1'b1, 2'd0},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 1'b0, 2'd0}
    };

    // Reference state built from the requirements.
    logic [31:0] m_save = '0, m_dbl = '0, m_addr = '0, m_dpc = '0;
    logic [5:0]  m_code = '0, m_dcode = '0, m_dst = '0;
    logic        m_excm = 1'b0, m_um = 1'b0;
    logic [3:0]  m_ilvl = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " save_pc"},  save_pc, m_save);
        chk({tag, " dbl_pc"},   dbl_pc,  m_dbl);
        chk({tag, " R5 code"},  {26'd0, fcode}, {26'd0, m_code});
        chk({tag, " R6 addr"},  faddr, m_addr);
        chk({tag, " R7 dcode"}, {26'd0, dcode}, {26'd0, m_dcode});
        chk({tag, " R7 dpc"},   dpc, m_dpc);
        chk({tag, " R7 dst"},   {26'd0, dst}, {26'd0, m_dst});
        chk({tag, " R10 st"},   {26'd0, st_excm_o, st_um_o, st_ilvl_o},
                                {26'd0, m_excm, m_um, m_ilvl});
    endtask

    // Model an ordinary exception dispatch (R2 R3 R4 R5 R6).
    task automatic model_exc();
        if (excm) m_dbl = pc; else m_save = pc;
        m_code = cause;
        if (vaddr_vld) m_addr = vaddr;
        m_excm = 1'b1; m_um = um; m_ilvl = ilvl;
    endtask

    // Model a debug entry (R7).
    task automatic model_dbg();
        m_dcode = dcause; m_dpc = pc; m_dst = {excm, um, ilvl};
        m_excm = 1'b1; m_um = um; m_ilvl = 4'd6;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 vld", {31'd0, vec_vld}, 32'd0);
        chk("R1 wr",  {31'd0, st_wr}, 32'd0);
        check_regs("R1");
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            exc_req   = TBL[i][10];
            dbg_req   = TBL[i][9];
            excm      = TBL[i][8];
            um        = TBL[i][7];
            ilvl      = TBL[i][6:3];
            pc        = 32'h1000_0000 + 32'(i * 16);
            cause     = 6'(i + 1);
            dcause    = 6'(i + 40);
            vaddr     = 32'hA000_0000 + 32'(i);
            vaddr_vld = i[0];
            if (TBL[i][2]) begin
                if (TBL[i][1:0] == 2'd3) model_dbg(); else model_exc();
            end
            @(posedge clk);
            @(negedge clk);
            exc_req = 1'b0; dbg_req = 1'b0;
            // R8 R9 R10: valid pulse presence
            chk($sformatf("R10 vld v%0d", i), {31'd0, vec_vld}, {31'd0, TBL[i][2]});
            chk($sformatf("R5 wr v%0d", i), {31'd0, st_wr}, {31'd0, TBL[i][2]});
            // R2 R3 R4 R7 R9: vector code
            if (TBL[i][2])
                chk($sformatf("R2/R3/R4/R7 vec v%0d", i), {30'd0, vec}, {30'd0, TBL[i][1:0]});
            check_regs($sformatf("v%0d", i));
        end

        // R10: back-to-back requests give one pulse each, then drop.
        exc_req = 1'b1; excm = 1'b0; um = 1'b1; ilvl = 4'd2;
        pc = 32'h2000_0000; cause = 6'd9; vaddr_vld = 1'b0;
        model_exc();
        @(posedge clk); @(negedge clk);
        chk("R10 b2b first", {30'd0, vec_vld, vec[0]}, 32'd3);
        excm = 1'b1; pc = 32'h2000_0040; cause = 6'd10;
        model_exc();
        @(posedge clk); @(negedge clk);
        exc_req = 1'b0;
        chk("R10 b2b second", {29'd0, vec_vld, vec}, 32'd6);
        check_regs("R10 b2b");
        @(posedge clk); @(negedge clk);
        chk("R10 pulse drop", {31'd0, vec_vld}, 32'd0);
        check_regs("R10 hold");

        // R1: reset in mid-run clears everything.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        m_save = '0; m_dbl = '0; m_addr = '0; m_dpc = '0;
        m_code = '0; m_dcode = '0; m_dst = '0;
        m_excm = 1'b0; m_um = 1'b0; m_ilvl = '0;
        chk("R1 mid vld", {31'd0, vec_vld}, 32'd0);
        check_regs("R1 mid");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule